// File: doc/BRIEF.md
# Condition Code Flag Unit

This block holds the 8-bit condition code register of a small 8/16-bit processor and computes its arithmetic flags. Each cycle the datapath may present a finished operation: its class, its operand size, both operands, the result the ALU produced and the bit a shifter pushed out. From these the block derives half-carry, negative, zero, overflow and carry. A per-flag enable from the decoder lets an instruction leave chosen flags untouched.

Software can also rewrite the register as a whole, or combine it with an immediate byte by AND, OR or XOR. The interrupt mask bit is forced to one by reset and by exception entry. The two user bits carry no hardware meaning and change only through software writes.

Bit layout, from bit 7 to bit 0: interrupt mask, user, half-carry, user, negative, zero, overflow, carry.

Top module: `cond_flag_reg`

## Requirements
- R1: While `rst_n` is low, bit 7 (interrupt mask) becomes 1 at the clock edge and bits 6..0 keep their values.
- R2: `exc_entry` high at a clock edge sets bit 7 to 1, even when a software write in the same cycle would clear it; other bits follow their normal update.
- R3: With `sw_wr` high, `sw_op` selects 0 = load `sw_imm`, 1 = AND with `sw_imm`, 2 = OR with `sw_imm`, 3 = XOR with `sw_imm`, applied to all 8 bits. A software write takes precedence over `op_valid` in the same cycle.
- R4: Class codes on `op_class`: 0 add, 1 subtract, 2 compare, 3 negate, 4 shift/rotate, 5 logic; codes 6 and 7 change no bit. For classes 0 to 3, bit 5 (H) is the carry (add) or borrow (others) out of bit 3 when `word_sz` is 0 and out of bit 11 when `word_sz` is 1. Classes 4 and 5 leave H unchanged.
- R5: For classes 0 to 5, bit 3 (N) is the top bit of the result (bit 7 for byte, bit 15 for word) and bit 2 (Z) is 1 exactly when the result is zero over the operand size; bits above 7 of operands and result are ignored for byte operations.
- R6: Bit 0 (C) is the carry out of the top bit for add, the borrow out of the top bit for subtract, compare and negate, and `shift_out` for shift/rotate; logic leaves C unchanged.
- R7: Bit 1 (V) is set on signed overflow: add when both operands share a sign and the result sign differs; subtract and compare (A minus B) when the operand signs differ and the result sign differs from A. Negate computes 0 minus `opnd_b` and ignores `opnd_a`. Shift and logic clear V.
- R8: `upd_mask` bits [4:0] enable H, N, Z, V, C in that order; a flag whose enable is 0 keeps its value. Operations never change bits 7, 6 and 4.
- R9: Bits 6 and 4 (user bits) change only through a software write and hold any value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_entry | input | 1 | Exception entry, forces interrupt mask |
| op_valid | input | 1 | An operation's flags are to be applied |
| op_class | input | 3 | Operation class code |
| word_sz | input | 1 | 1 = 16-bit operation, 0 = 8-bit |
| opnd_a | input | 16 | First operand (minuend for subtract) |
| opnd_b | input | 16 | Second operand (subtrahend, negate operand) |
| result | input | 16 | Result produced by the ALU |
| shift_out | input | 1 | Bit pushed out by the shifter |
| upd_mask | input | 5 | Per-flag update enables H,N,Z,V,C |
| sw_wr | input | 1 | Software write strobe |
| sw_op | input | 2 | Software write operation |
| sw_imm | input | 8 | Software immediate byte |
| ccr_q | output | 8 | Register contents |

## Verification
The bench aims at the half-carry tap switching between bit 3 and bit 11: a word add of 0x000F+1 must leave H clear while 0x0FFF+1 sets it, so a design with a fixed tap flips one of them. Byte operations are driven with junk in the upper operand and result bytes, which a design reading the wrong top bit or zero range would turn into wrong N, Z or C. Negate of 0x80 and 0x00, borrows from compare, signed overflow on both add and subtract, masked updates, the collision of a software write that clears the mask with exception entry, and a reset in mid-run that must preserve the low seven bits are each checked, since a wrong precedence or a full-register reset shows up directly on the register.

// File: rtl/cond_flag_reg.sv
module cond_flag_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        exc_entry,
  input  logic        op_valid,
  input  logic [2:0]  op_class,
  input  logic        word_sz,
  input  logic [15:0] opnd_a,
  input  logic [15:0] opnd_b,
  input  logic [15:0] result,
  input  logic        shift_out,
  input  logic [4:0]  upd_mask,
  input  logic        sw_wr,
  input  logic [1:0]  sw_op,
  input  logic [7:0]  sw_imm,
  output logic [7:0]  ccr_q
);
  localparam logic [2:0] CL_ADD = 3'd0, CL_SUB = 3'd1, CL_CMP = 3'd2,
                         CL_NEG = 3'd3, CL_SHF = 3'd4, CL_LOG = 3'd5;

  logic        mask_q;
  logic [6:0]  low_q;
  logic [7:0]  nxt;

  assign ccr_q = {mask_q, low_q};

  wire is_add   = op_class == CL_ADD;
  wire is_sub   = op_class == CL_SUB || op_class == CL_CMP || op_class == CL_NEG;
  wire is_arith = is_add || is_sub;
  wire is_shf   = op_class == CL_SHF;
  wire is_log   = op_class == CL_LOG;

  wire [15:0] a  = (op_class == CL_NEG) ? 16'h0000 : opnd_a;
  wire [15:0] cx = a ^ opnd_b ^ result;

  wire am = word_sz ? a[15]      : a[7];
  wire bm = word_sz ? opnd_b[15] : opnd_b[7];
  wire rm = word_sz ? result[15] : result[7];

  wire h_new = word_sz ? cx[12] : cx[4];
  wire z_new = word_sz ? (result == 16'h0000) : (result[7:0] == 8'h00);
  wire c_add = (am & bm) | ((am ^ bm) & ~rm);
  wire c_sub = (~am & bm) | (~(am ^ bm) & rm);
  wire v_add = ~(am ^ bm) & (am ^ rm);
  wire v_sub = (am ^ bm) & (am ^ rm);

  always_comb begin
    nxt = ccr_q;
    if (sw_wr) begin
      case (sw_op)
        2'd0:    nxt = sw_imm;
        2'd1:    nxt = ccr_q & sw_imm;
        2'd2:    nxt = ccr_q | sw_imm;
        default: nxt = ccr_q ^ sw_imm;
      endcase
    end else if (op_valid && (is_arith || is_shf || is_log)) begin
      if (upd_mask[4] && is_arith) nxt[5] = h_new;
      if (upd_mask[3]) nxt[3] = rm;
      if (upd_mask[2]) nxt[2] = z_new;
      if (upd_mask[1]) nxt[1] = is_add ? v_add : (is_sub ? v_sub : 1'b0);
      if (upd_mask[0] && !is_log) nxt[0] = is_add ? c_add : (is_sub ? c_sub : shift_out);
    end
    if (exc_entry) nxt[7] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= 1'b1;
    else        mask_q <= nxt[7];
  end

  always_ff @(posedge clk) begin
    if (rst_n) low_q <= nxt[6:0];
  end

  // R1
  rst_mask_chk: assert property (@(posedge clk) !rst_n |=> ccr_q[7]);

  // R2
  exc_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry |=> ccr_q[7]);

  // R6
  shift_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !sw_wr && op_class == CL_SHF && upd_mask[0]) |=> ccr_q[0] == $past(shift_out));

  // R7
  logic_v_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !sw_wr && op_class == CL_LOG && upd_mask[1]) |=> !ccr_q[1]);

  // R8
  mask_c_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !sw_wr && !upd_mask[0] && !$isunknown(ccr_q)) |=> $stable(ccr_q[0]));

  // R9
  user_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr && !$isunknown(ccr_q)) |=> $stable({ccr_q[6], ccr_q[4]}));
endmodule

// File: tb/test_cond_flag_reg.sv
module test_cond_flag_reg;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        exc_entry = 0;
  logic        op_valid = 0;
  logic [2:0]  op_class = 0;
  logic        word_sz = 0;
  logic [15:0] opnd_a = 0, opnd_b = 0, result = 0;
  logic        shift_out = 0;
  logic [4:0]  upd_mask = 5'h1F;
  logic        sw_wr = 0;
  logic [1:0]  sw_op = 0;
  logic [7:0]  sw_imm = 0;
  logic [7:0]  ccr_q;

  int checks = 0, fails = 0;
  logic [7:0] exp_q;
  logic       done = 0;

  cond_flag_reg i_cond_flag_reg (.*);

  always #2.5 clk = ~clk;

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic int sx(int v, int w);
    return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
  endfunction

  function automatic logic [7:0] model(logic [7:0] q);
    logic [7:0] n = q;
    int w, msk, hm, ua, ub, r, full;
    logic h, c, v;
    w = word_sz ? 16 : 8;
    msk = (1 << w) - 1;
    hm = word_sz ? 'hFFF : 'hF;
    ua = (op_class == 3) ? 0 : int'(opnd_a) & msk;
    ub = int'(opnd_b) & msk;
    r = int'(result) & msk;
    h = 0; c = 0; v = 0;
    if (sw_wr) begin
      case (sw_op)
        0: n = sw_imm;
        1: n = q & sw_imm;
        2: n = q | sw_imm;
        default: n = q ^ sw_imm;
      endcase
    end else if (op_valid && op_class <= 5) begin
      if (op_class == 0) begin
        full = ua + ub; c = (full >> w) & 1;
        h = ((ua & hm) + (ub & hm)) > hm;
        full = sx(ua, w) + sx(ub, w); v = full > (1 << (w-1)) - 1 || full < -(1 << (w-1));
      end else if (op_class <= 3) begin
        c = ua < ub; h = (ua & hm) < (ub & hm);
        full = sx(ua, w) - sx(ub, w); v = full > (1 << (w-1)) - 1 || full < -(1 << (w-1));
      end else if (op_class == 4) c = shift_out;
      if (upd_mask[4] && op_class <= 3) n[5] = h;
      if (upd_mask[3]) n[3] = (r >> (w - 1)) & 1;
      if (upd_mask[2]) n[2] = (r == 0);
      if (upd_mask[1]) n[1] = v;
      if (upd_mask[0] && op_class != 5) n[0] = c;
    end
    if (exc_entry) n[7] = 1;
    if (!rst_n) n = {1'b1, q[6:0]};
    return n;
  endfunction

  task automatic check(string req);
    checks++;
    if (ccr_q !== exp_q) begin
      fails++;
      $display("FAIL %s: ccr_q=%02h expected %02h", req, ccr_q, exp_q);
    end
  endtask

  task automatic step(string req);
    exp_q = model(exp_q);
    @(negedge clk);
    check(req);
    op_valid = 0; sw_wr = 0; exc_entry = 0; upd_mask = 5'h1F;
  endtask

  function automatic logic [15:0] alu(int cls, logic [15:0] a, logic [15:0] b);
    case (cls)
      0: return a + b;
      1, 2: return a - b;
      3: return 16'h0 - b;
      default: return a;
    endcase
  endfunction

  task automatic op(string req, int cls, logic wsz, logic [15:0] a, logic [15:0] b);
    logic [15:0] r = alu(cls, a, b);
    op_valid = 1; op_class = cls[2:0]; word_sz = wsz; opnd_a = a; opnd_b = b;
    result = wsz ? r : {8'hA5, r[7:0]};
    step(req);
  endtask

  task automatic swr(string req, int o, logic [7:0] imm);
    sw_wr = 1; sw_op = o[1:0]; sw_imm = imm;
    step(req);
  endtask

  initial begin
    exp_q = 8'h80;
    @(negedge clk); @(negedge clk);
    checks++;
    if (ccr_q[7] !== 1'b1) begin fails++; $display("FAIL R1: mask=%b expected 1", ccr_q[7]); end
    rst_n = 1;
    swr("R3 load", 0, 8'h00);
    step("R3 idle hold");
    // R4 byte half-carry out of bit 3
    op("R4 byte add H", 0, 0, 16'hFF0F, 16'h3301);
    // R7 add overflow, R5 N
    op("R7 add V", 0, 0, 16'h007F, 16'h0001);
    // R6 carry, R5 zero
    op("R6 add C Z", 0, 0, 16'h00FF, 16'h0001);
    // R4 word tap at bit 11
    op("R4 word add no H", 0, 1, 16'h000F, 16'h0001);
    op("R4 word add H", 0, 1, 16'h0FFF, 16'h0001);
    op("R6 word add C", 0, 1, 16'hFFFF, 16'h0001);
    op("R4 byte sub borrow", 1, 0, 16'h0010, 16'h0001);
    op("R6 cmp borrow", 2, 0, 16'h0000, 16'h0001);
    op("R7 sub V", 1, 0, 16'h0080, 16'h0001);
    op("R7 word sub V", 2, 1, 16'h8000, 16'h0001);
    op("R7 neg 80", 3, 0, 16'h1234, 16'h0080);
    op("R6 neg zero", 3, 0, 16'h00FF, 16'h0000);
    op("R5 byte upper ignored", 2, 0, 16'h1255, 16'h3455);
    // R6 shift carry from shift_out, R7 V cleared
    shift_out = 1; op("R6 shift", 4, 0, 16'h0081, 16'h0);
    shift_out = 0; op("R6 shift zero", 4, 1, 16'h8000, 16'h0);
    swr("R3 or", 2, 8'h23);
    op("R7 logic clears V keeps H C", 5, 0, 16'h0000, 16'h0);
    // R8 masked updates
    upd_mask = 5'b00100; op("R8 only Z", 0, 0, 16'h00FF, 16'h0001);
    upd_mask = 5'b00000; op("R8 none", 1, 0, 16'h0000, 16'h0001);
    op("R4 class 6 no change", 6, 0, 16'h0000, 16'h0001);
    swr("R3 and", 1, 8'hF0);
    swr("R3 xor", 3, 8'h5A);
    swr("R9 user bits", 0, 8'h50);
    // R3 precedence over op_valid
    op_valid = 1; op_class = 0; opnd_a = 16'hFF; opnd_b = 16'h01; result = 16'h0;
    swr("R3 sw over op", 0, 8'h01);
    exc_entry = 1; step("R2 exc");
    exc_entry = 1; swr("R2 exc beats sw clear", 1, 8'h7F);
    swr("R1 preload", 0, 8'h3F);
    rst_n = 0; step("R1 reset keeps low bits");
    rst_n = 1; step("R1 after reset");
    for (int i = 0; i < 300; i++) begin
      op_valid = $urandom_range(0, 1); op_class = 3'($urandom_range(0, 7));
      word_sz = 1'($urandom); opnd_a = 16'($urandom); opnd_b = 16'($urandom);
      result = alu(op_class, opnd_a, opnd_b);
      shift_out = 1'($urandom); upd_mask = 5'($urandom);
      sw_wr = ($urandom_range(0, 7) == 0); sw_op = 2'($urandom); sw_imm = 8'($urandom);
      exc_entry = ($urandom_range(0, 15) == 0);
      step("R8 random mix");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule